// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

The resolver takes eight peripheral interrupt request lines and picks one winning source per clock. Each source owns a 4-bit priority code, and the eight codes share one 32-bit configuration word. A simple write strobe loads that word, and a read port returns it. Among pending sources the one with the larger code wins. Equal codes fall to the lower source index.

The top bit of each code is a bank bit. A winner whose bank bit is set drives the critical (high-level) interrupt output. Any other winner drives the low-level output. Source 0 is special: when it is pending it always wins and always raises the high-level output, whatever its nibble holds. Its nibble is still stored and read back. The winner index, a valid flag and the two level outputs are all registered.

Top module: `irq_pri_resolver`

## Requirements
- R1: After reset the configuration word reads 0. A write of cfg_wdata while cfg_we is high is returned unchanged on cfg_rdata from the next cycle, including the source 0 nibble (bits 31:28).
- R2: The code of source i sits in cfg bits [31-4i : 28-4i]. Source 0 uses the most significant nibble and source 7 the least significant nibble. Request bit irq_req[i] belongs to source i.
- R3: Among pending sources 1 to 7, the one with the numerically larger unsigned code wins. A code with bit 3 set therefore outranks any code with bit 3 clear.
- R4: When pending sources 1 to 7 have equal codes, zero or non-zero, the lowest index among them wins.
- R5: When irq_req[0] is sampled high, the winner is index 0 with irq_hi high, whatever source 0's nibble or the other codes hold.
- R6: When the winner is not source 0, irq_hi equals bit 3 of its code and irq_lo is its inverse. Whenever win_valid is high, exactly one of irq_hi and irq_lo is high.
- R7: When no request is sampled, win_valid, irq_hi and irq_lo are low and win_idx is 0.
- R8: The outputs reflect the requests and configuration present at the previous clock edge. A configuration write first affects the outputs at the second rising edge after the strobe is sampled.
- R9: A synchronous active-high rst clears the configuration and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Stored configuration word |
| irq_req | input | 8 | Request lines, bit i is source i |
| win_idx | output | 3 | Index of the winning source |
| win_valid | output | 1 | A request is pending and won |
| irq_hi | output | 1 | Critical-level interrupt |
| irq_lo | output | 1 | Low-level interrupt |

## Verification
Some properties are checked on every cycle. The high and low outputs are never both high when valid and never high when idle. An idle cycle always reports index 0. A sampled source 0 request always gives index 0 on the high output. A write is always stored exactly as given. Only the bench scenarios show the ordering choices: which pending source wins for given codes, lower-index tie-breaking, the bank bit outranking lower codes, the nibble layout and the one-cycle write latency.

// File: rtl/irq_pri_pkg.sv
package irq_pri_pkg;
  localparam int unsigned DEF_SRC_COUNT = 8;
  localparam int unsigned DEF_CODE_BITS = 4;

  // Extract field `slot` of width `fw` from a word numbered msb-first.
  function automatic logic [31:0] msb_first_field(
    input logic [255:0] word,
    input int unsigned  total_w,
    input int unsigned  fw,
    input int unsigned  slot
  );
    logic [31:0] r;
    r = '0;
    for (int unsigned b = 0; b < fw; b++) begin
      r[b] = word[total_w - (slot + 1) * fw + b];
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_pri_cfg.sv
module irq_pri_cfg #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (we) begin
      word <= wdata;
    end
  end

  // R1
  cfg_store_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !$past(rst)) |-> (word == $past(wdata)));
endmodule

// File: rtl/irq_pri_tree.sv
module irq_pri_tree
  import irq_pri_pkg::*;
#(
  parameter int unsigned SRC_COUNT = DEF_SRC_COUNT,
  parameter int unsigned CODE_BITS = DEF_CODE_BITS,
  localparam int unsigned WORD_W   = SRC_COUNT * CODE_BITS,
  localparam int unsigned IDX_W    = (SRC_COUNT > 1) ? $clog2(SRC_COUNT) : 1,
  localparam int unsigned LEVELS   = $clog2(SRC_COUNT),
  localparam int unsigned KEY_W    = CODE_BITS + 1
) (
  input  logic [WORD_W-1:0]    cfg,
  input  logic [SRC_COUNT-1:0] req,
  output logic                 any,
  output logic [IDX_W-1:0]     idx,
  output logic                 hi
);
  logic [255:0] cfg_wide;
  assign cfg_wide = 256'(cfg);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int unsigned NODES = SRC_COUNT >> l;
    logic             v [NODES];
    logic [KEY_W-1:0] k [NODES];
    logic [IDX_W-1:0] n [NODES];
    logic             h [NODES];

    if (l == 0) begin : g_leaf
      for (genvar s = 0; s < NODES; s++) begin : g_src
        logic [CODE_BITS-1:0] code;
        assign code = CODE_BITS'(msb_first_field(cfg_wide, WORD_W, CODE_BITS, s));
        assign v[s] = req[s];
        assign n[s] = IDX_W'(s);
        if (s == 0) begin : g_fixed
          // source 0 outranks every code and always lands on the critical level
          assign k[s] = {1'b1, {CODE_BITS{1'b0}}};
          assign h[s] = 1'b1;
        end else begin : g_prog
          assign k[s] = {1'b0, code};
          assign h[s] = code[CODE_BITS-1];
        end
      end
    end else begin : g_merge
      for (genvar j = 0; j < NODES; j++) begin : g_pair
        logic take_r;
        // left child holds lower indices, so it keeps ties
        assign take_r = g_lvl[l-1].v[2*j+1] &&
                        (!g_lvl[l-1].v[2*j] ||
                         (g_lvl[l-1].k[2*j+1] > g_lvl[l-1].k[2*j]));
        assign v[j] = g_lvl[l-1].v[2*j] | g_lvl[l-1].v[2*j+1];
        assign k[j] = take_r ? g_lvl[l-1].k[2*j+1] : g_lvl[l-1].k[2*j];
        assign n[j] = take_r ? g_lvl[l-1].n[2*j+1] : g_lvl[l-1].n[2*j];
        assign h[j] = take_r ? g_lvl[l-1].h[2*j+1] : g_lvl[l-1].h[2*j];
      end
    end
  end

  assign any = g_lvl[LEVELS].v[0];
  assign idx = any ? g_lvl[LEVELS].n[0] : '0;
  assign hi  = any & g_lvl[LEVELS].h[0];
endmodule

// File: rtl/irq_pri_out.sv
module irq_pri_out #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             hi_in,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx,
  output logic             irq_hi,
  output logic             irq_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_idx   <= '0;
      irq_hi    <= 1'b0;
      irq_lo    <= 1'b0;
    end else begin
      win_valid <= any;
      win_idx   <= any ? idx_in : '0;
      irq_hi    <= any & hi_in;
      irq_lo    <= any & ~hi_in;
    end
  end

  // R6
  one_level_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (irq_hi ^ irq_lo));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> (!irq_hi && !irq_lo && win_idx == '0));
endmodule

// File: rtl/irq_pri_resolver.sv
module irq_pri_resolver
  import irq_pri_pkg::*;
#(
  parameter int unsigned SRC_COUNT = DEF_SRC_COUNT,
  parameter int unsigned CODE_BITS = DEF_CODE_BITS,
  localparam int unsigned WORD_W   = SRC_COUNT * CODE_BITS,
  localparam int unsigned IDX_W    = (SRC_COUNT > 1) ? $clog2(SRC_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [WORD_W-1:0]    cfg_wdata,
  output logic [WORD_W-1:0]    cfg_rdata,
  input  logic [SRC_COUNT-1:0] irq_req,
  output logic [IDX_W-1:0]     win_idx,
  output logic                 win_valid,
  output logic                 irq_hi,
  output logic                 irq_lo
);
  logic [WORD_W-1:0] cfg_word;
  logic              tree_any;
  logic [IDX_W-1:0]  tree_idx;
  logic              tree_hi;

  irq_pri_cfg #(.WORD_W(WORD_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .word  (cfg_word)
  );

  irq_pri_tree #(.SRC_COUNT(SRC_COUNT), .CODE_BITS(CODE_BITS)) u_tree (
    .cfg (cfg_word),
    .req (irq_req),
    .any (tree_any),
    .idx (tree_idx),
    .hi  (tree_hi)
  );

  irq_pri_out #(.IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .any       (tree_any),
    .idx_in    (tree_idx),
    .hi_in     (tree_hi),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .irq_hi    (irq_hi),
    .irq_lo    (irq_lo)
  );

  assign cfg_rdata = cfg_word;

  // R5
  src0_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_req[0]) && !$past(rst)) |-> (win_valid && win_idx == '0 && irq_hi));

  // R7
  no_req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_req) == '0 && !$past(rst)) |-> !win_valid);
endmodule

// File: tb/tb_irq_pri_resolver.sv
module tb_irq_pri_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  irq_req = '0;
  logic [2:0]  win_idx;
  logic        win_valid, irq_hi, irq_lo;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_pri_resolver dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_req(irq_req), .win_idx(win_idx),
    .win_valid(win_valid), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  // {cfg[31:0], req[7:0], idx[3:0], flags[3:0]}; flags: 3 = valid+hi, 2 = valid+lo, 0 = idle
  localparam int NV = 12;
  localparam logic [47:0] VEC [NV] = '{
    48'h00000000_00_0_0,  // R7 idle
    48'h00000000_06_1_2,  // R4 zero-code tie
    48'h01234567_FE_7_2,  // R3 largest code
    48'h0123456F_82_7_3,  // R6 bank bit high
    48'hF0000000_01_0_3,  // R5 source 0 alone
    48'h00000000_FF_0_3,  // R5 source 0 code zero still wins
    48'h05555555_A8_3_2,  // R4 nonzero tie
    48'h08700000_06_1_3,  // R3 8 beats 7
    48'h07800000_06_2_3,  // R3 swapped
    48'h0000000C_81_0_3,  // R5 beats high code
    48'h09A00000_06_2_3,  // R3 A beats 9
    48'h00000010_C0_6_2   // R2 nibble layout, src6 = 1
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [2:0] eidx, input logic ev, input logic eh);
    chk({tag, " idx"},   32'(win_idx), 32'(eidx));
    chk({tag, " valid"}, 32'(win_valid), 32'(ev));
    chk({tag, " hi"},    32'(irq_hi), 32'(eh));
    chk({tag, " lo"},    32'(irq_lo), 32'(ev & ~eh));
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 / R1 reset state
    chk("R9 rdata", cfg_rdata, 32'h0);
    chk_out("R9 reset", 3'd0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][47:16]);
      chk($sformatf("R1 readback v%0d", i), cfg_rdata, VEC[i][47:16]);
      irq_req = VEC[i][15:8];
      @(negedge clk);
      chk_out($sformatf("R3 vec%0d", i), VEC[i][6:4], VEC[i][1], VEC[i][0]);
    end

    // R1 source 0 nibble stored as written
    write_cfg(32'hA0000000);
    chk("R1 src0 nibble", cfg_rdata, 32'hA0000000);

    // R8 write latency: src2 wins under old cfg, src1 under new cfg
    write_cfg(32'h01200000);
    irq_req = 8'h06;
    @(negedge clk);
    chk_out("R8 before", 3'd2, 1'b1, 1'b0);
    cfg_we = 1'b1;
    cfg_wdata = 32'h02100000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk_out("R8 first edge", 3'd2, 1'b1, 1'b0);
    @(negedge clk);
    chk_out("R8 second edge", 3'd1, 1'b1, 1'b0);

    // R8 request removal seen one edge later
    irq_req = 8'h00;
    @(negedge clk);
    chk_out("R8 R7 release", 3'd0, 1'b0, 1'b0);

    // R9 reset mid run
    irq_req = 8'h80;
    write_cfg(32'h0000000F);
    @(negedge clk);
    chk_out("R9 pre", 3'd7, 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 cfg cleared", cfg_rdata, 32'h0);
    chk_out("R9 outputs cleared", 3'd0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R9 R4 after reset", 3'd7, 1'b1, 1'b0);

    finish_run();
  end
endmodule